// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the thirty-two 32-bit data registers of a fixed-point geometry coprocessor. A host bus writes one register per clock through a 5-bit index and reads any register combinationally through a second, independent index. Several indices do more than store a word. Some keep only a 16-bit field and extend it. One index is a push alias for a three-deep screen-coordinate queue. Two indices convert between a packed 5-5-5 colour word and three 16-bit intensity registers. One index feeds a leading-bit counter whose result appears in a read-only neighbour.

The arithmetic side of the coprocessor has a dedicated load port that writes the three intensity registers (indices 9, 10 and 11) in one cycle. The control register bank and the arithmetic commands sit outside this block.

Top module: `cop_data_regs`

## Requirements
- R1: A write to index 1, 3, 5, 8, 9, 10 or 11 stores wrData[15:0] sign-extended to 32 bits.
- R2: A write to index 7, 16, 17, 18 or 19 stores wrData[15:0] zero-extended to 32 bits.
- R3: A write to index 15 shifts the coordinate queue in one edge: index 12 takes the old index 13, index 13 takes the old index 14, and index 14 takes the written word.
- R4: A read of index 15 returns the contents of index 14.
- R5: A write to index 28 loads index 9 with wrData[4:0]*128, index 10 with wrData[9:5]*128 and index 11 with wrData[14:10]*128, each as a non-negative 32-bit value.
- R6: A read of index 28 or 29 returns {17'b0, b, g, r}, with r in bits [4:0], g in [9:5] and b in [14:10]. Each field is the matching intensity register (index 9, 10, 11) divided by 128, truncated toward zero and clamped to 0..31.
- R7: A write to index 30 stores the full word. On the same edge, index 31 is set to the count of leading bits equal to bit 31, a value from 1 to 32.
- R8: Writes to index 29 and index 31 change no register.
- R9: On synchronous reset every register reads as zero on the next cycle.
- R10: When intLoadEn is high, indices 9, 10 and 11 take intVal1, intVal2 and intVal3 sign-extended. This load overrides a bus write to those indices in the same cycle.
- R11: A write to any other index stores the full 32-bit word, and a read of any index other than 15, 28 and 29 returns the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Bus write strobe |
| wrIdx | input | 5 | Bus write index |
| wrData | input | 32 | Bus write data |
| rdIdx | input | 5 | Read index |
| rdData | output | 32 | Combinational read data |
| intLoadEn | input | 1 | Arithmetic-side load of the three intensity registers |
| intVal1 | input | 16 | Value for index 9 |
| intVal2 | input | 16 | Value for index 10 |
| intVal3 | input | 16 | Value for index 11 |

## Verification
The bench targets the edges of the leading-bit count. All zeros and all ones must both give 32, and a value whose top two bits differ must give 1. A counter that only counts zeros, or that stops at 31, fails these cases. On colour readback it drives a negative intensity and an intensity far above 31*128. A design that forgets the clamp shows wrapped or sign-smeared fields. It pushes the queue several times in a row and reads through the alias, which exposes a shift done in the wrong order or an alias pointing at a stale entry. Finally, it collides an internal load with a bus write to the same intensity register, so a reversed priority shows up as the bus value.

// File: rtl/cop_dreg_pkg.sv
package cop_dreg_pkg;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 5;
  localparam int HALF_W  = 16;
  localparam int FIELD_W = 5;
  localparam int FIELD_SHIFT = 7;
  localparam int NUM_CH  = 3;
  localparam int NUM_REG = 1 << IDX_W;
  localparam int CNT_W   = $clog2(DATA_W + 1);

  localparam logic [IDX_W-1:0] IDX_Q0     = 5'd12;
  localparam logic [IDX_W-1:0] IDX_Q1     = 5'd13;
  localparam logic [IDX_W-1:0] IDX_Q2     = 5'd14;
  localparam logic [IDX_W-1:0] IDX_QPUSH  = 5'd15;
  localparam logic [IDX_W-1:0] IDX_INT1   = 5'd9;
  localparam logic [IDX_W-1:0] IDX_COLIN  = 5'd28;
  localparam logic [IDX_W-1:0] IDX_COLOUT = 5'd29;
  localparam logic [IDX_W-1:0] IDX_CSRC   = 5'd30;
  localparam logic [IDX_W-1:0] IDX_CRES   = 5'd31;

  typedef struct packed {
    logic sext16;
    logic zext16;
    logic plainStore;
    logic queuePush;
    logic colorUnpack;
    logic countLoad;
  } wrStrobe_t;
endpackage

// File: rtl/cop_dreg_ctrl.sv
module cop_dreg_ctrl
  import cop_dreg_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output wrStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (wrIdx)
        5'd1, 5'd3, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11: strobe.sext16 = 1'b1;
        5'd7, 5'd16, 5'd17, 5'd18, 5'd19:           strobe.zext16 = 1'b1;
        IDX_QPUSH:                                  strobe.queuePush = 1'b1;
        IDX_COLIN:                                  strobe.colorUnpack = 1'b1;
        IDX_CSRC:                                   strobe.countLoad = 1'b1;
        IDX_COLOUT, IDX_CRES:                       strobe = '0;
        default:                                    strobe.plainStore = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cop_dreg_leadcnt.sv
module cop_dreg_leadcnt
  import cop_dreg_pkg::*;
(
  input  logic [DATA_W-1:0] value,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] folded;
  assign folded = value[DATA_W-1] ? ~value : value;

  always_comb begin
    count = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (folded[i]) count = CNT_W'(DATA_W - 1 - i);
    end
  end
endmodule

// File: rtl/cop_dreg_datapath.sv
module cop_dreg_datapath
  import cop_dreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              intLoadEn,
  input  logic [HALF_W-1:0] intVal [NUM_CH]
);
  localparam int PAD_W = DATA_W - FIELD_W - FIELD_SHIFT;
  localparam int FMAX  = (1 << FIELD_W) - 1;

  logic [DATA_W-1:0] regFile [NUM_REG];
  logic [CNT_W-1:0]  leadCount;
  logic [FIELD_W-1:0] packField [NUM_CH];
  logic [DATA_W-1:0] packedColor;

  cop_dreg_leadcnt u_leadcnt (.value(wrData), .count(leadCount));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REG; i++) regFile[i] <= '0;
    end else begin
      if (strobe.sext16)
        regFile[wrIdx] <= {{(DATA_W-HALF_W){wrData[HALF_W-1]}}, wrData[HALF_W-1:0]};
      if (strobe.zext16)
        regFile[wrIdx] <= {{(DATA_W-HALF_W){1'b0}}, wrData[HALF_W-1:0]};
      if (strobe.plainStore)
        regFile[wrIdx] <= wrData;
      if (strobe.queuePush) begin
        regFile[IDX_Q0] <= regFile[IDX_Q1];
        regFile[IDX_Q1] <= regFile[IDX_Q2];
        regFile[IDX_Q2] <= wrData;
      end
      if (strobe.colorUnpack) begin
        regFile[IDX_COLIN] <= {{(DATA_W-NUM_CH*FIELD_W){1'b0}}, wrData[NUM_CH*FIELD_W-1:0]};
        for (int c = 0; c < NUM_CH; c++)
          regFile[IDX_INT1 + c] <= {{PAD_W{1'b0}}, wrData[c*FIELD_W +: FIELD_W], {FIELD_SHIFT{1'b0}}};
      end
      if (strobe.countLoad) begin
        regFile[IDX_CSRC] <= wrData;
        regFile[IDX_CRES] <= {{(DATA_W-CNT_W){1'b0}}, leadCount};
      end
      if (intLoadEn) begin
        for (int c = 0; c < NUM_CH; c++)
          regFile[IDX_INT1 + c] <= {{(DATA_W-HALF_W){intVal[c][HALF_W-1]}}, intVal[c]};
      end
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_pack
      logic signed [DATA_W-1:0] level;
      logic [DATA_W-1:0] scaled;
      assign level  = signed'(regFile[IDX_INT1 + ch]);
      assign scaled = regFile[IDX_INT1 + ch] >> FIELD_SHIFT;
      always_comb begin
        if (level < 0)             packField[ch] = '0;
        else if (scaled > FMAX)    packField[ch] = FIELD_W'(FMAX);
        else                       packField[ch] = scaled[FIELD_W-1:0];
      end
    end
  endgenerate

  assign packedColor = {{(DATA_W-NUM_CH*FIELD_W){1'b0}}, packField[2], packField[1], packField[0]};

  always_comb begin
    case (rdIdx)
      IDX_QPUSH:             rdData = regFile[IDX_Q2];
      IDX_COLIN, IDX_COLOUT: rdData = packedColor;
      default:               rdData = regFile[rdIdx];
    endcase
  end

  // R1: sign extension of a half-word store
  p_sext_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe.sext16 && wrIdx == 5'd1) |=> regFile[1] == {{16{$past(wrData[15])}}, $past(wrData[15:0])});

  // R2: zero extension of a half-word store
  p_zext_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.zext16 && wrIdx == 5'd7) |=> regFile[7][31:16] == 16'h0);

  // R3: coordinate queue shifts by one on a push
  p_queue_shift_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.queuePush |=> (regFile[IDX_Q0] == $past(regFile[IDX_Q1]) &&
                          regFile[IDX_Q1] == $past(regFile[IDX_Q2]) &&
                          regFile[IDX_Q2] == $past(wrData)));

  // R7: leading-bit result lies in 1..32
  p_count_range_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.countLoad |=> (regFile[IDX_CRES] >= 1 && regFile[IDX_CRES] <= DATA_W));

  // R8: the result register holds its value when the write does not load the counter
  p_readonly_r8: assert property (@(posedge clk) disable iff (rst)
    !strobe.countLoad |=> $stable(regFile[IDX_CRES]));

  // R10: internal load wins for the intensity registers
  p_intload_r10: assert property (@(posedge clk) disable iff (rst)
    intLoadEn |=> regFile[IDX_INT1] == {{16{$past(intVal[0][15])}}, $past(intVal[0])});
endmodule

// File: rtl/cop_data_regs.sv
module cop_data_regs
  import cop_dreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              intLoadEn,
  input  logic [HALF_W-1:0] intVal1,
  input  logic [HALF_W-1:0] intVal2,
  input  logic [HALF_W-1:0] intVal3
);
  wrStrobe_t strobe;
  logic [HALF_W-1:0] intVal [NUM_CH];

  assign intVal[0] = intVal1;
  assign intVal[1] = intVal2;
  assign intVal[2] = intVal3;

  cop_dreg_ctrl u_ctrl (.wrEn(wrEn), .wrIdx(wrIdx), .strobe(strobe));

  cop_dreg_datapath u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .intLoadEn(intLoadEn), .intVal(intVal)
  );
endmodule

// File: tb/cop_data_regs_tb.sv
`timescale 1ns/1ps
module cop_data_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        intLoadEn = 1'b0;
  logic [15:0] intVal1 = '0, intVal2 = '0, intVal3 = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [32];

  always #2.5 clk = ~clk;

  cop_data_regs dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .intLoadEn(intLoadEn),
    .intVal1(intVal1), .intVal2(intVal2), .intVal3(intVal3)
  );

  function automatic logic [31:0] leadBits(logic [31:0] v);
    int n = 0;
    for (int b = 31; b >= 0; b--) begin
      if (v[b] != v[31]) break;
      n++;
    end
    return 32'(n);
  endfunction

  function automatic logic [31:0] packColor();
    logic [31:0] res = '0;
    for (int c = 0; c < 3; c++) begin
      int lv = int'(signed'(mdl[9 + c]));
      int f = (lv < 0) ? 0 : lv / 128;
      if (f > 31) f = 31;
      res |= 32'(f) << (5 * c);
    end
    return res;
  endfunction

  function automatic void mdlWrite(int idx, logic [31:0] d);
    case (idx)
      1, 3, 5, 8, 9, 10, 11: mdl[idx] = {{16{d[15]}}, d[15:0]};
      7, 16, 17, 18, 19:     mdl[idx] = {16'h0, d[15:0]};
      15: begin mdl[12] = mdl[13]; mdl[13] = mdl[14]; mdl[14] = d; end
      28: begin
        mdl[28] = {17'h0, d[14:0]};
        for (int c = 0; c < 3; c++) mdl[9 + c] = 32'(d[5*c +: 5]) * 128;
      end
      30: begin mdl[30] = d; mdl[31] = leadBits(d); end
      29, 31: ;
      default: mdl[idx] = d;
    endcase
  endfunction

  function automatic logic [31:0] mdlRead(int idx);
    if (idx == 15) return mdl[14];
    if (idx == 28 || idx == 29) return packColor();
    return mdl[idx];
  endfunction

  function automatic string tagOf(int idx);
    case (idx)
      1, 3, 5, 8, 9, 10, 11: return "R1";
      7, 16, 17, 18, 19:     return "R2";
      15:     return "R3";
      28, 29: return "R6";
      30:     return "R7";
      31:     return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic doWrite(int idx, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    mdlWrite(idx, d);
  endtask

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkRead(int idx, string tag);
    rdIdx = 5'(idx);
    #1;
    checkVal($sformatf("%s idx=%0d", tag, idx), rdData, mdlRead(idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-requirements actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    for (int i = 0; i < 32; i++) checkRead(i, "R9");

    // R1 sign extension
    doWrite(1, 32'hFFFF_8001); checkRead(1, "R1");
    checkVal("R1 neg", rdData, 32'hFFFF_8001);
    doWrite(8, 32'h1234_7FFF); checkRead(8, "R1");
    checkVal("R1 pos", rdData, 32'h0000_7FFF);
    // R2 zero extension
    doWrite(17, 32'hABCD_9876); checkRead(17, "R2");
    checkVal("R2 lit", rdData, 32'h0000_9876);
    doWrite(7, 32'hFFFF_FFFF); checkRead(7, "R2");

    // R3 / R4 queue
    doWrite(12, 32'h1111_1111); doWrite(13, 32'h2222_2222); doWrite(14, 32'h3333_3333);
    doWrite(15, 32'hAAAA_0001); doWrite(15, 32'hBBBB_0002);
    checkRead(12, "R3"); checkVal("R3 q0", rdData, 32'h3333_3333);
    checkRead(13, "R3"); checkVal("R3 q1", rdData, 32'hAAAA_0001);
    checkRead(14, "R3");
    checkRead(15, "R4"); checkVal("R4 alias", rdData, 32'hBBBB_0002);

    // R5 / R6 colour
    doWrite(28, 32'hFFFF_FFFF);
    checkRead(9, "R5"); checkVal("R5 f", rdData, 32'h0000_0F80);
    checkRead(10, "R5"); checkRead(11, "R5");
    checkRead(28, "R6"); checkVal("R6 full", rdData, 32'h0000_7FFF);
    doWrite(28, 32'h0000_1234);
    checkRead(9, "R5"); checkRead(10, "R5"); checkRead(11, "R5");
    doWrite(9, 32'h0000_8000); doWrite(10, 32'h0000_7FFF); doWrite(11, 32'h0000_0100);
    checkRead(29, "R6"); checkVal("R6 clamp", rdData, 32'h0000_0BE0);
    checkRead(28, "R6");

    // R7 leading bits
    doWrite(30, 32'h0000_0000); checkRead(31, "R7"); checkVal("R7 zero", rdData, 32'd32);
    doWrite(30, 32'hFFFF_FFFF); checkRead(31, "R7"); checkVal("R7 ones", rdData, 32'd32);
    doWrite(30, 32'h0001_0000); checkRead(31, "R7"); checkVal("R7 mid", rdData, 32'd15);
    doWrite(30, 32'h8000_0000); checkRead(31, "R7"); checkVal("R7 msb", rdData, 32'd1);
    doWrite(30, 32'h7FFF_FFFF); checkRead(31, "R7"); checkVal("R7 top", rdData, 32'd1);
    checkRead(30, "R7");

    // R8 read-only indices
    doWrite(31, 32'h0000_00FF); checkRead(31, "R8"); checkVal("R8 res", rdData, 32'd1);
    doWrite(29, 32'hFFFF_FFFF); checkRead(29, "R8"); checkVal("R8 col", rdData, 32'h0000_0BE0);
    checkRead(9, "R8"); checkRead(10, "R8"); checkRead(11, "R8");

    // R10 internal load beats bus write
    @(negedge clk);
    intLoadEn = 1'b1; intVal1 = 16'h8123; intVal2 = 16'h0456; intVal3 = 16'hFFFF;
    wrEn = 1'b1; wrIdx = 5'd9; wrData = 32'h0000_1111;
    @(negedge clk);
    intLoadEn = 1'b0; wrEn = 1'b0;
    mdl[9] = 32'hFFFF_8123; mdl[10] = 32'h0000_0456; mdl[11] = 32'hFFFF_FFFF;
    checkRead(9, "R10"); checkVal("R10 win", rdData, 32'hFFFF_8123);
    checkRead(10, "R10"); checkRead(11, "R10");

    // R11 plain store
    doWrite(0, 32'hDEAD_BEEF); checkRead(0, "R11"); checkVal("R11 lit", rdData, 32'hDEAD_BEEF);
    doWrite(24, 32'h8000_0001); checkRead(24, "R11");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int idx = int'($urandom_range(0, 31));
      int other = int'($urandom_range(0, 31));
      logic [31:0] d = $urandom;
      if (($urandom & 3) == 0) d = {{16{d[15]}}, d[15:0]};
      doWrite(idx, d);
      checkRead(idx, tagOf(idx));
      checkRead(other, tagOf(other));
    end

    // R9: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    for (int i = 0; i < 32; i++) checkRead(i, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule